// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from a set of peripheral channels and routes each one to one of two classes. The fast class drives a dedicated fast interrupt line, and a status word tells the fast handler which of its channels are asserting. The vectored class drives the normal interrupt line. For that class the block picks a single winner by a programmable per-channel priority and returns that winner's handler address when software reads the vector register.

Software programs the controller over a simple single-cycle register bus. Read data appears one clock after the read strobe. A read of the vector register marks the winner's priority level as in service. While that level is in service, requests of the same or lower urgency are held off. A write to the same register ends service of the most urgent in-service level. Because service levels are tracked per level, a higher-priority interrupt can nest inside a lower one.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, `fiq_o` and `irq_o` are 0, and the class word (offset 0x03), enable word (offset 0x04) and default address (offset 0x06) read back as 0.
- R2: The raw status word (offset 0x00) returns the request input levels, whatever the enable and class settings.
- R3: The fast status word (offset 0x01) returns request AND enable AND class, where class bit 1 selects the fast class. `fiq_o` is the OR of those bits, registered, so it follows a request change one clock later.
- R4: The vectored status word (offset 0x02) returns request AND enable AND NOT class, and ignores any in-service state.
- R5: A channel with its enable bit at 0 never affects `fiq_o` or `irq_o` and never wins arbitration, even when it has priority 0.
- R6: A vector register read (offset 0x05) returns the programmed address (offset 0x80+n) of the active, enabled vectored channel with the numerically smallest 4-bit priority (offset 0x40+n, bits 3:0). Priority 0 is the most urgent.
- R7: Among eligible vectored channels of equal priority, the lowest-numbered channel wins.
- R8: With no eligible vectored request, a vector read returns the default address and changes no service state.
- R9: A vector read with a winner puts that winner's priority level in service. From then on only requests with a strictly smaller priority value can raise `irq_o` or win.
- R10: Any write to offset 0x05 takes the most urgent level out of service. With nothing in service, `irq_o` equals the registered OR of all enabled vectored requests.
- R11: A fast-class channel never wins vectored arbitration and never raises `irq_o`.
- R12: The class, enable, default, priority and vector address registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | NCH | Level request per channel |
| bus_sel_i | input | 1 | Register access strobe, one cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Word offset of the register |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, valid the clock after the strobe |
| fiq_o | output | 1 | Fast interrupt request to the processor |
| irq_o | output | 1 | Vectored interrupt request to the processor |

## Verification
Directed cases cover three arbitration situations. Two equal-priority channels show that the tie-break favours the lower channel. A priority-0 channel that is masked, or moved to the fast class, shows that neither one takes part in vectoring. A low-priority service interrupted by a more urgent channel shows nesting and that each acknowledge undoes one level. Random request, enable and class words then run against a bench model of the service levels. Each vector read and the acknowledges between reads move that model, which separates errors in priority comparison, tie order and threshold tracking.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_AW = 8;
  localparam logic [REG_AW-1:0] A_RAW     = 8'h00;
  localparam logic [REG_AW-1:0] A_FSTAT   = 8'h01;
  localparam logic [REG_AW-1:0] A_ISTAT   = 8'h02;
  localparam logic [REG_AW-1:0] A_CLASS   = 8'h03;
  localparam logic [REG_AW-1:0] A_ENABLE  = 8'h04;
  localparam logic [REG_AW-1:0] A_VECT    = 8'h05;
  localparam logic [REG_AW-1:0] A_DEFAULT = 8'h06;
  localparam logic [1:0]        PAGE_PRIO = 2'b01;  // 0x40..0x7F
  localparam logic [1:0]        PAGE_VEC  = 2'b10;  // 0x80..0xBF
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int NCH = 32,
  parameter int DW  = 32,
  parameter int PW  = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [REG_AW-1:0]      bus_addr,
  input  logic [DW-1:0]          bus_wdata,
  input  logic [NCH-1:0]         src,
  input  logic                   win_valid,
  input  logic [CH_W-1:0]        win_idx,
  output logic [DW-1:0]          rdata,
  output logic [NCH-1:0]         class_q,
  output logic [NCH-1:0]         en_q,
  output logic [NCH-1:0][PW-1:0] prio_q,
  output logic                   vect_rd,
  output logic                   vect_ack
);
  logic [DW-1:0]   vec_mem [NCH];
  logic [DW-1:0]   dflt_q;
  logic [DW-1:0]   rd_mux;
  logic [CH_W-1:0] idx;
  logic            idx_ok, wr_en, rd_en, in_prio, in_vec;

  assign idx     = bus_addr[CH_W-1:0];
  assign idx_ok  = int'(bus_addr[5:0]) < NCH;
  assign wr_en   = bus_sel && bus_wr;
  assign rd_en   = bus_sel && !bus_wr;
  assign in_prio = (bus_addr[7:6] == PAGE_PRIO) && idx_ok;
  assign in_vec  = (bus_addr[7:6] == PAGE_VEC) && idx_ok;
  assign vect_rd  = rd_en && (bus_addr == A_VECT);
  assign vect_ack = wr_en && (bus_addr == A_VECT);

  always_ff @(posedge clk) begin
    if (rst) begin
      class_q <= '0;
      en_q    <= '0;
      dflt_q  <= '0;
    end else if (wr_en) begin
      if (bus_addr == A_CLASS)   class_q <= bus_wdata[NCH-1:0];
      if (bus_addr == A_ENABLE)  en_q    <= bus_wdata[NCH-1:0];
      if (bus_addr == A_DEFAULT) dflt_q  <= bus_wdata;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst) prio_q[c] <= '1;
      else if (wr_en && in_prio && (idx == CH_W'(c))) prio_q[c] <= bus_wdata[PW-1:0];
    end
  end

  // Address table kept free of reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en && in_vec) vec_mem[idx] <= bus_wdata;
  end

  always_comb begin
    rd_mux = '0;
    if (in_prio)      rd_mux = DW'(prio_q[idx]);
    else if (in_vec)  rd_mux = vec_mem[idx];
    else begin
      case (bus_addr)
        A_RAW:     rd_mux = DW'(src);
        A_FSTAT:   rd_mux = DW'(src & en_q & class_q);
        A_ISTAT:   rd_mux = DW'(src & en_q & ~class_q);
        A_CLASS:   rd_mux = DW'(class_q);
        A_ENABLE:  rd_mux = DW'(en_q);
        A_VECT:    rd_mux = win_valid ? vec_mem[win_idx] : dflt_q;
        A_DEFAULT: rd_mux = dflt_q;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NCH = 32,
  parameter int PW  = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]         req,
  input  logic [NCH-1:0][PW-1:0] prio,
  input  logic [PW:0]            thresh,
  output logic                   win_valid,
  output logic [CH_W-1:0]        win_idx,
  output logic [PW-1:0]          win_prio
);
  logic [PW:0] best;

  // Strict less-than while scanning upward keeps the lowest channel on ties.
  always_comb begin
    best      = thresh;
    win_valid = 1'b0;
    win_idx   = '0;
    for (int c = 0; c < NCH; c++) begin
      if (req[c] && ({1'b0, prio[c]} < best)) begin
        best      = {1'b0, prio[c]};
        win_idx   = CH_W'(c);
        win_valid = 1'b1;
      end
    end
    win_prio = best[PW-1:0];
  end
endmodule

// File: rtl/vic_service.sv
module vic_service #(
  parameter int PW = 4,
  localparam int NLVL = 1 << PW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [PW-1:0]   take_lvl,
  input  logic            ack,
  output logic [NLVL-1:0] inserv,
  output logic [PW:0]     thresh
);
  logic [NLVL-1:0] nxt;

  always_comb begin
    thresh = (PW+1)'(NLVL);
    for (int l = NLVL-1; l >= 0; l--) begin
      if (inserv[l]) thresh = (PW+1)'(l);
    end
  end

  always_comb begin
    nxt = inserv;
    if (ack)  nxt = nxt & (nxt - 1'b1);   // drop the most urgent level
    if (take) nxt[take_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) inserv <= '0;
    else     inserv <= nxt;
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NCH = 32,
  parameter int DW  = 32,
  parameter int PW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    irq_src_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int NLVL = 1 << PW;

  logic [NCH-1:0]         class_q, en_q, vreq;
  logic [NCH-1:0][PW-1:0] prio_q;
  logic                   vect_rd, ack, take, win_valid;
  logic [CH_W-1:0]        win_idx;
  logic [PW-1:0]          win_prio;
  logic [PW:0]            thresh;
  logic [NLVL-1:0]        inserv;

  vic_regs #(.NCH(NCH), .DW(DW), .PW(PW)) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel_i), .bus_wr(bus_wr_i), .bus_addr(bus_addr_i), .bus_wdata(bus_wdata_i),
    .src(irq_src_i), .win_valid(win_valid), .win_idx(win_idx),
    .rdata(bus_rdata_o), .class_q(class_q), .en_q(en_q), .prio_q(prio_q),
    .vect_rd(vect_rd), .vect_ack(ack)
  );

  assign vreq = irq_src_i & en_q & ~class_q;

  vic_arbiter #(.NCH(NCH), .PW(PW)) u_arb (
    .req(vreq), .prio(prio_q), .thresh(thresh),
    .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio)
  );

  assign take = vect_rd && win_valid;

  vic_service #(.PW(PW)) u_svc (
    .clk(clk), .rst(rst), .take(take), .take_lvl(win_prio), .ack(ack),
    .inserv(inserv), .thresh(thresh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      fiq_o <= |(irq_src_i & en_q & class_q);
      irq_o <= win_valid;
    end
  end
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
  parameter int NCH = 32,
  parameter int PW  = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int NLVL = 1 << PW
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NCH-1:0]        irq_src_i,
  input logic                  fiq_o,
  input logic                  irq_o,
  input logic [NCH-1:0]        class_q,
  input logic [NCH-1:0]        en_q,
  input logic                  win_valid,
  input logic [CH_W-1:0]       win_idx,
  input logic [PW-1:0]         win_prio,
  input logic [PW:0]           thresh,
  input logic                  take,
  input logic                  ack,
  input logic [NLVL-1:0]       inserv
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!fiq_o && !irq_o)); // R1

  AST_NO_REQ_NO_OUT: assert property (@(posedge clk) disable iff (rst)
    (irq_src_i == '0) |=> (!fiq_o && !irq_o)); // R5

  AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (irq_src_i[win_idx] && en_q[win_idx])); // R5

  AST_WIN_NOT_FAST: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> !class_q[win_idx]); // R11

  AST_BELOW_THRESH: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> ({1'b0, win_prio} < thresh)); // R9

  AST_TAKE_MARKS: assert property (@(posedge clk) disable iff (rst)
    (take && !ack) |=> inserv[$past(win_prio)]); // R9

  AST_ACK_DROPS_ONE: assert property (@(posedge clk) disable iff (rst)
    (ack && !take && (inserv != '0)) |=> ($countones(inserv) + 1 == $countones($past(inserv)))); // R10
endmodule

bind vic_ctrl vic_ctrl_chk #(.NCH(NCH), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .irq_src_i(irq_src_i), .fiq_o(fiq_o), .irq_o(irq_o),
  .class_q(class_q), .en_q(en_q), .win_valid(win_valid), .win_idx(win_idx),
  .win_prio(win_prio), .thresh(thresh), .take(take), .ack(ack), .inserv(inserv)
);

// File: tb/vic_ctrl_test.sv
module vic_ctrl_test;
  localparam int NCH = 32;
  localparam int DW  = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] src = '0;
  logic           sel = 1'b0, wr = 1'b0;
  logic [7:0]     addr = '0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;
  logic           fiq, irq;

  int n_tests = 0, n_fail = 0;
  logic [31:0] m_class = '0, m_en = '0, m_dflt = '0;
  int          m_prio [NCH];
  logic [31:0] m_vec  [NCH];
  logic [15:0] m_ins = '0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  vic_ctrl #(.NCH(NCH), .DW(DW), .PW(4)) uut (
    .clk(clk), .rst(rst), .irq_src_i(src), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int m_thresh();
    for (int l = 0; l < 16; l++) if (m_ins[l]) return l;
    return 16;
  endfunction

  function automatic int m_win();
    int best = m_thresh();
    int w = -1;
    for (int c = 0; c < NCH; c++)
      if (src[c] && m_en[c] && !m_class[c] && m_prio[c] < best) begin
        best = m_prio[c]; w = c;
      end
    return w;
  endfunction

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
    if (a == 8'h03) m_class = d;
    if (a == 8'h04) m_en = d;
    if (a == 8'h06) m_dflt = d;
    if (a >= 8'h40 && a < 8'h40 + NCH) m_prio[a - 8'h40] = int'(d[3:0]);
    if (a >= 8'h80 && a < 8'h80 + NCH) m_vec[a - 8'h80] = d;
    if (a == 8'h05) m_ins = m_ins & (m_ins - 16'd1);
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; d = rdata;
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " R3 fiq"}, {31'd0, fiq}, {31'd0, |(src & m_en & m_class)});
    chk({tag, " R10 irq"}, {31'd0, irq}, {31'd0, m_win() >= 0});
  endtask

  task automatic read_vect(input string tag);
    int w = m_win();
    logic [31:0] exp = (w >= 0) ? m_vec[w] : m_dflt;
    bread(8'h05, rv);
    chk({tag, " R6 vector"}, rv, exp);
    if (w >= 0) m_ins[m_prio[w]] = 1'b1;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < NCH; c++) begin m_prio[c] = 15; m_vec[c] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 fiq", {31'd0, fiq}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    bread(8'h04, rv); chk("R1 enable", rv, 32'd0);
    bread(8'h03, rv); chk("R1 class", rv, 32'd0);
    bread(8'h06, rv); chk("R1 default", rv, 32'd0);

    // R12 programming and readback
    bwrite(8'h06, 32'hDEAD_0000);
    for (int c = 0; c < NCH; c++) begin
      bwrite(8'h40 + 8'(c), 32'($urandom_range(1, 15)));
      bwrite(8'h80 + 8'(c), 32'h1000_0000 + 32'(c * 16));
    end
    bread(8'h47, rv); chk("R12 prio readback", rv, 32'(m_prio[7]));
    bread(8'h93, rv); chk("R12 vector readback", rv, m_vec[19]);
    bread(8'h06, rv); chk("R12 default readback", rv, 32'hDEAD_0000);

    // R2 raw status with everything masked
    src = 32'hA5A5_0F0F; settle();
    bread(8'h00, rv); chk("R2 raw", rv, 32'hA5A5_0F0F);
    chk("R5 irq masked", {31'd0, irq}, 32'd0);
    // R8 default with no eligible request
    read_vect("R8");
    chk("R8 default", rv, 32'hDEAD_0000);

    // R5 masked priority-0 channel does not win
    bwrite(8'h40, 32'd0);
    bwrite(8'h45, 32'd3); bwrite(8'h49, 32'd3);
    bwrite(8'h04, 32'hFFFF_FFFE);
    src = 32'h0000_0221; settle();
    check_outputs("R5");
    // R7 tie between channels 5 and 9
    read_vect("R7");
    chk("R7 lowest channel", rv, m_vec[5]);
    bwrite(8'h05, 32'd0);
    // R11 channel 5 to fast class
    bwrite(8'h03, 32'h0000_0020); settle();
    check_outputs("R11");
    bread(8'h01, rv); chk("R3 fast status", rv, 32'h0000_0020);
    bread(8'h02, rv); chk("R4 irq status", rv, 32'h0000_0200);
    read_vect("R11");
    chk("R11 skips fast", rv, m_vec[9]);
    // R9 nesting: channel 9 in service, channel 2 more urgent
    settle();
    chk("R9 held off", {31'd0, irq}, 32'd0);
    bread(8'h02, rv); chk("R4 ignores service", rv, 32'h0000_0200);
    bwrite(8'h42, 32'd1);
    src = 32'h0000_0224; settle();
    chk("R9 nested raise", {31'd0, irq}, 32'd1);
    read_vect("R9");
    chk("R9 nested win", rv, m_vec[2]);
    bwrite(8'h05, 32'd0); settle();
    check_outputs("R10 first ack");
    bwrite(8'h05, 32'd0); settle();
    check_outputs("R10 second ack");
    read_vect("R10"); bwrite(8'h05, 32'd0);

    // Random mix
    for (int i = 0; i < 150; i++) begin
      if ($urandom_range(0, 3) == 0) bwrite(8'h04, $urandom());
      if ($urandom_range(0, 4) == 0) bwrite(8'h03, $urandom() & $urandom());
      if ($urandom_range(0, 5) == 0) bwrite(8'h40 + 8'($urandom_range(0, NCH-1)), 32'($urandom_range(0, 15)));
      src = $urandom() & $urandom();
      settle();
      check_outputs("rand");
      case ($urandom_range(0, 2))
        0: begin bread(8'h00, rv); chk("R2 rand raw", rv, src); end
        1: begin bread(8'h01, rv); chk("R3 rand fast", rv, src & m_en & m_class); end
        default: begin bread(8'h02, rv); chk("R4 rand irq", rv, src & m_en & ~m_class); end
      endcase
      read_vect("rand");
      if ($urandom_range(0, 9) < 7) bwrite(8'h05, 32'd0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule